// File: doc/BRIEF.md
# Loader Memory Dump and CRC Engine

This block is the command back end of a boot-loader slave. A transport layer, which is not part of the block, hands it command frames one byte at a time over a valid/ready byte stream, and takes back response bytes over a second valid/ready stream. Three commands are served. One reads a range of the data memory and returns the bytes as they are. The other two walk a range of either the program memory or the data memory and return a 16-bit CRC of that range. Every response ends with a fixed completion byte.

Both memories are read through plain synchronous read ports with one cycle of latency. An unlock level, driven by password logic outside the block, decides whether a frame may touch memory at all. A locked frame gets an error byte in place of its payload. The CRC walk takes several cycles per byte. A busy output lets a host poll until the first response byte is ready. The stream address is 16 bits wide. Each memory port keeps only the low PAW or DAW bits of it (1 to 16), so a walk wraps within the memory.

Top module: `ldr_walk_crc`

## Requirements
- R1: Byte 0 of a frame selects the command: 21h dumps data memory, 30h computes a CRC over program memory, and 31h computes a CRC over data memory. Any other code still consumes a whole 7-byte frame but produces no response and leaves busy low.
- R2: A frame is 7 bytes in this order: command, count (accepted but not checked), start address low, start address high, length low, length high, and a pad byte. in_ready stays low from the cycle after the pad byte is accepted until the last response byte has been accepted.
- R3: A dump returns exactly `length` bytes. These are the data memory contents at start, start+1 and so on, taken modulo 2^DAW. Then comes 3Eh.
- R4: The CRC uses polynomial 8005h. The register starts at 0000h, each byte is fed MSB first one bit per clock, and there is no final inversion. The reply is the CRC low byte, then the CRC high byte, then 3Eh.
- R5: A length of zero makes no memory read. A dump then replies with 3Eh alone, and a CRC command replies with 00h, 00h, 3Eh.
- R6: unlock is sampled in the cycle after the pad byte is accepted. If it is low, no memory is read and the reply is FFh followed by 3Eh.
- R7: busy is high from the cycle after the pad byte of a recognised frame is accepted, up to and including the first cycle in which the first response byte is valid. It is low in the cycle after that.
- R8: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged.
- R9: Memory is read with a one-cycle latency. A 30h frame reads only the program port, the other commands read only the data port, and each byte of the range is read exactly once.

Top module parameters: PAW and DAW (address widths of the program and data ports, each 1 to 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock | input | 1 | Access granted by external password logic |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| in_data | input | 8 | Command byte |
| out_valid | output | 1 | Response byte valid |
| out_ready | input | 1 | Response byte taken when high with out_valid |
| out_data | output | 8 | Response byte |
| busy | output | 1 | Command in progress, no response byte yet |
| prog_addr | output | PAW | Program memory read address |
| prog_rd_en | output | 1 | Program memory read strobe |
| prog_rdata | input | 8 | Program memory read data, one cycle after strobe |
| data_addr | output | DAW | Data memory read address |
| data_rd_en | output | 1 | Data memory read strobe |
| data_rdata | input | 8 | Data memory read data, one cycle after strobe |

## Verification
The end of the busy window and the first valid response byte fall in the same cycle. This overlap is tightest on zero-length and locked frames, where the reply is valid one cycle after the frame completes. The bench provokes this with those frames and with normal dumps and CRC walks, and holds out_ready low for several cycles on the first byte. It judges the result by sampling busy and out_valid on the falling edge: busy must be high in the first valid cycle and low in every later one, and the held byte must not change.

// File: rtl/ldr_walk_pkg.sv
package ldr_walk_pkg;

    localparam logic [7:0]  CMD_DUMP      = 8'h21;
    localparam logic [7:0]  CMD_CRC_PROG  = 8'h30;
    localparam logic [7:0]  CMD_CRC_DATA  = 8'h31;
    localparam logic [7:0]  RESP_DONE     = 8'h3E;
    localparam logic [7:0]  RESP_LOCKED   = 8'hFF;
    localparam logic [15:0] CRC_POLY      = 16'h8005;
    localparam logic [15:0] CRC_INIT      = 16'h0000;
    localparam int          FRAME_BYTES   = 7;
    localparam int          BYTE_BITS     = 8;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_DUMP,
        OP_CRC_PROG,
        OP_CRC_DATA
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [15:0] addr;
        logic [15:0] len;
    } req_t;

    typedef enum logic [3:0] {
        W_IDLE,
        W_READ,
        W_CAPT,
        W_BITS,
        W_OUT_DAT,
        W_OUT_ERR,
        W_OUT_CL,
        W_OUT_CH,
        W_OUT_END
    } wstate_e;

    function automatic op_e decode_cmd(input logic [7:0] code);
        case (code)
            CMD_DUMP:     return OP_DUMP;
            CMD_CRC_PROG: return OP_CRC_PROG;
            CMD_CRC_DATA: return OP_CRC_DATA;
            default:      return OP_NONE;
        endcase
    endfunction

    function automatic logic [15:0] crc_bit(input logic [15:0] cur, input logic din);
        logic fb;
        fb = cur[15] ^ din;
        return {cur[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/ldr_frame_rx.sv
module ldr_frame_rx
    import ldr_walk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       hold,
    output req_t       req,
    output logic       start
);
    localparam int IW = $clog2(FRAME_BYTES);

    logic [IW-1:0] idx;
    logic [7:0]    cmd_q;
    req_t          req_q;
    logic          start_q;
    logic          take;

    assign in_ready = !hold && !start_q;
    assign take     = in_valid && in_ready;
    assign req      = req_q;
    assign start    = start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            cmd_q   <= '0;
            req_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (take) begin
                case (int'(idx))
                    0: cmd_q            <= in_data;
                    2: req_q.addr[7:0]  <= in_data;
                    3: req_q.addr[15:8] <= in_data;
                    4: req_q.len[7:0]   <= in_data;
                    5: req_q.len[15:8]  <= in_data;
                    default: ;
                endcase
                if (idx == IW'(FRAME_BYTES - 1)) begin
                    idx      <= '0;
                    req_q.op <= decode_cmd(cmd_q);
                    start_q  <= (decode_cmd(cmd_q) != OP_NONE);
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R2: a start pulse lasts one cycle and follows an accepted pad byte
    assert_start_single_R2: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);
    assert_start_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        start_q |-> $past(take));

endmodule

// File: rtl/ldr_crc_ser.sv
module ldr_crc_ser
    import ldr_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        load,
    input  logic [7:0]  din,
    output logic [15:0] crc,
    output logic        idle
);
    localparam int CW = $clog2(BYTE_BITS + 1);

    logic [CW-1:0] cnt;
    logic [7:0]    sh;
    logic [15:0]   crc_q;

    assign crc  = crc_q;
    assign idle = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_INIT;
            cnt   <= '0;
            sh    <= '0;
        end else if (clear) begin
            crc_q <= CRC_INIT;
            cnt   <= '0;
        end else if (load) begin
            sh  <= din;
            cnt <= CW'(BYTE_BITS);
        end else if (cnt != '0) begin
            crc_q <= crc_bit(crc_q, sh[7]);
            sh    <= {sh[6:0], 1'b0};
            cnt   <= cnt - 1'b1;
        end
    end

    // R4: a byte is only loaded into an idle shifter, and then one bit per clock
    assert_load_idle_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> idle);
    assert_bit_per_clock_R4: assert property (@(posedge clk) disable iff (rst)
        (!idle && !clear && !load) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/ldr_walk_seq.sv
module ldr_walk_seq
    import ldr_walk_pkg::*;
#(
    parameter int PAW = 10,
    parameter int DAW = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  req_t           req,
    input  logic           unlock,
    output logic [PAW-1:0] prog_addr,
    output logic           prog_rd_en,
    input  logic [7:0]     prog_rdata,
    output logic [DAW-1:0] data_addr,
    output logic           data_rd_en,
    input  logic [7:0]     data_rdata,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [7:0]     out_data,
    output logic           idle
);
    wstate_e     st;
    op_e         op_q;
    logic [15:0] cur;
    logic [15:0] remain;
    logic [7:0]  out_q;
    logic [7:0]  rbyte;
    logic        accept;
    logic        last;
    logic        crc_clear;
    logic        crc_load;
    logic        crc_idle;
    logic [15:0] crc_val;

    assign prog_rd_en = (st == W_READ) && (op_q == OP_CRC_PROG);
    assign data_rd_en = (st == W_READ) && (op_q != OP_CRC_PROG);
    assign prog_addr  = cur[PAW-1:0];
    assign data_addr  = cur[DAW-1:0];
    assign rbyte      = (op_q == OP_CRC_PROG) ? prog_rdata : data_rdata;
    assign crc_clear  = (st == W_IDLE) && start;
    assign crc_load   = (st == W_CAPT) && (op_q != OP_DUMP);
    assign out_valid  = st inside {W_OUT_DAT, W_OUT_ERR, W_OUT_CL, W_OUT_CH, W_OUT_END};
    assign accept     = out_valid && out_ready;
    assign out_data   = out_q;
    assign idle       = (st == W_IDLE);
    assign last       = (remain == 16'd1);

    ldr_crc_ser u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (crc_clear),
        .load  (crc_load),
        .din   (rbyte),
        .crc   (crc_val),
        .idle  (crc_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= W_IDLE;
            op_q   <= OP_NONE;
            cur    <= '0;
            remain <= '0;
            out_q  <= '0;
        end else begin
            case (st)
                W_IDLE: if (start) begin
                    op_q   <= req.op;
                    cur    <= req.addr;
                    remain <= req.len;
                    if (!unlock) begin
                        out_q <= RESP_LOCKED;
                        st    <= W_OUT_ERR;
                    end else if (req.len == 16'd0) begin
                        if (req.op == OP_DUMP) begin
                            out_q <= RESP_DONE;
                            st    <= W_OUT_END;
                        end else begin
                            out_q <= CRC_INIT[7:0];
                            st    <= W_OUT_CL;
                        end
                    end else begin
                        st <= W_READ;
                    end
                end
                W_READ: st <= W_CAPT;
                W_CAPT: begin
                    if (op_q == OP_DUMP) begin
                        out_q <= rbyte;
                        st    <= W_OUT_DAT;
                    end else begin
                        st <= W_BITS;
                    end
                end
                W_BITS: if (crc_idle) begin
                    cur    <= cur + 16'd1;
                    remain <= remain - 16'd1;
                    if (last) begin
                        out_q <= crc_val[7:0];
                        st    <= W_OUT_CL;
                    end else begin
                        st <= W_READ;
                    end
                end
                W_OUT_DAT: if (accept) begin
                    cur    <= cur + 16'd1;
                    remain <= remain - 16'd1;
                    if (last) begin
                        out_q <= RESP_DONE;
                        st    <= W_OUT_END;
                    end else begin
                        st <= W_READ;
                    end
                end
                W_OUT_ERR: if (accept) begin
                    out_q <= RESP_DONE;
                    st    <= W_OUT_END;
                end
                W_OUT_CL: if (accept) begin
                    out_q <= crc_val[15:8];
                    st    <= W_OUT_CH;
                end
                W_OUT_CH: if (accept) begin
                    out_q <= RESP_DONE;
                    st    <= W_OUT_END;
                end
                W_OUT_END: if (accept) st <= W_IDLE;
                default: st <= W_IDLE;
            endcase
        end
    end

    // R8: a stalled response byte does not move
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R6: a locked frame answers with the error byte at once
    assert_locked_reply_R6: assert property (@(posedge clk) disable iff (rst)
        (idle && start && !unlock) |=> (out_valid && out_data == RESP_LOCKED && !prog_rd_en && !data_rd_en));
    // R5: a zero-length frame answers without any read
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (rst)
        (idle && start && unlock && req.len == 16'd0) |=> (out_valid && !prog_rd_en && !data_rd_en));
    // R9: one port per read, data captured one cycle later
    assert_one_port_R9: assert property (@(posedge clk) disable iff (rst)
        !(prog_rd_en && data_rd_en));
    assert_read_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (prog_rd_en || data_rd_en) |=> (st == W_CAPT));

endmodule

// File: rtl/ldr_walk_crc.sv
module ldr_walk_crc
    import ldr_walk_pkg::*;
#(
    parameter int PAW = 10,
    parameter int DAW = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           unlock,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [7:0]     in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [7:0]     out_data,
    output logic           busy,
    output logic [PAW-1:0] prog_addr,
    output logic           prog_rd_en,
    input  logic [7:0]     prog_rdata,
    output logic [DAW-1:0] data_addr,
    output logic           data_rd_en,
    input  logic [7:0]     data_rdata
);
    req_t req;
    logic start;
    logic seq_idle;
    logic busy_q;

    ldr_frame_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .hold     (!seq_idle),
        .req      (req),
        .start    (start)
    );

    ldr_walk_seq #(.PAW(PAW), .DAW(DAW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req        (req),
        .unlock     (unlock),
        .prog_addr  (prog_addr),
        .prog_rd_en (prog_rd_en),
        .prog_rdata (prog_rdata),
        .data_addr  (data_addr),
        .data_rd_en (data_rd_en),
        .data_rdata (data_rdata),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .idle       (seq_idle)
    );

    always_ff @(posedge clk) begin
        if (rst)            busy_q <= 1'b0;
        else if (start)     busy_q <= 1'b1;
        else if (out_valid) busy_q <= 1'b0;
    end

    assign busy = start | busy_q;

    // R7: busy ends right after the first response byte shows up
    assert_busy_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && out_valid) |=> !busy);
    // R2: no command byte is taken while a response is pending
    assert_no_input_in_reply_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

endmodule

// File: tb/ldr_walk_crc_test.sv
`timescale 1ns/1ps
module ldr_walk_crc_test;
    localparam int AW  = 6;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          unlock = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          out_ready = 1'b0;
    logic          in_ready, out_valid, busy;
    logic [7:0]    out_data;
    logic [AW-1:0] prog_addr, data_addr;
    logic          prog_rd_en, data_rd_en;
    logic [7:0]    prog_rdata = 8'h00;
    logic [7:0]    data_rdata = 8'h00;

    int errs = 0;
    int checks = 0;
    int prd = 0;
    int drd = 0;

    always #4 clk = ~clk;

    ldr_walk_crc #(.PAW(AW), .DAW(AW)) uut (
        .clk(clk), .rst(rst), .unlock(unlock),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy),
        .prog_addr(prog_addr), .prog_rd_en(prog_rd_en), .prog_rdata(prog_rdata),
        .data_addr(data_addr), .data_rd_en(data_rd_en), .data_rdata(data_rdata)
    );

    function automatic logic [7:0] pm(input int a);
        return 8'((a % MSZ) * 37 + 11);
    endfunction
    function automatic logic [7:0] dm(input int a);
        return 8'(((a % MSZ) * 13) ^ 8'h5A);
    endfunction

    always @(posedge clk) begin
        if (prog_rd_en) begin prog_rdata <= pm(int'(prog_addr)); prd <= prd + 1; end
        if (data_rd_en) begin data_rdata <= dm(int'(data_addr)); drd <= drd + 1; end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ref_crc(input int addr, input int len, input bit prog);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < len; i++) begin
            logic [7:0] b = prog ? pm(addr + i) : dm(addr + i);
            for (int k = 7; k >= 0; k--) begin
                if (c[15] ^ b[k]) c = (c << 1) ^ 16'h8005;
                else              c = c << 1;
            end
        end
        return int'(c);
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input logic [7:0] cmd, input int addr, input int len,
                       input bit unl, input int stall, input string tag);
        int exp[$];
        int c;
        bit waitbad = 0;
        bit stallbad = 0;
        unlock = unl;
        send(cmd); send(8'h02); send(8'(addr)); send(8'(addr >> 8));
        send(8'(len)); send(8'(len >> 8));
        prd = 0; drd = 0;
        send(8'h00);
        chk("R7 busy after pad byte", int'(busy), 1);
        if (!unl) begin
            exp.push_back(8'hFF);
        end else if (cmd == 8'h21) begin
            for (int i = 0; i < len; i++) exp.push_back(int'(dm(addr + i)));
        end else begin
            c = ref_crc(addr, len, cmd == 8'h30);
            exp.push_back(c & 255);
            exp.push_back(c >> 8);
        end
        exp.push_back(8'h3E);
        foreach (exp[i]) begin
            logic [7:0] d;
            out_ready = 1'b0;
            while (!out_valid) begin
                if (i == 0 && !busy) waitbad = 1;
                @(negedge clk);
            end
            if (i == 0) chk("R7 busy with first byte", int'(busy), 1);
            if (i == 0) chk("R2 input blocked during reply", int'(in_ready), 0);
            d = out_data;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                if (!out_valid || out_data != d) stallbad = 1;
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            chk($sformatf("%s byte %0d", tag, i), int'(d), exp[i]);
            if (i == 0) chk("R7 busy low after first byte", int'(busy), 0);
        end
        chk("R7 busy high while waiting", int'(waitbad), 0);
        if (stall > 0) chk("R8 stalled byte held", int'(stallbad), 0);
        chk("R9 program reads", prd, (unl && cmd == 8'h30) ? len : 0);
        chk("R9 data reads", drd, (unl && cmd != 8'h30) ? len : 0);
        chk("R2 input ready after reply", int'(in_ready), 1);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset in_ready", int'(in_ready), 1);
        chk("R7 reset busy", int'(busy), 0);
        chk("R8 reset out_valid", int'(out_valid), 0);
        chk("R9 reset reads", int'(prog_rd_en | data_rd_en), 0);

        // R1: unknown code consumes a frame and stays silent
        unlock = 1'b1;
        send(8'h22); send(8'h02); send(8'h21); send(8'h30);
        send(8'h31); send(8'h00); send(8'h00);
        for (int k = 0; k < 6; k++) begin
            chk("R1 unknown command silent", int'(out_valid | busy), 0);
            @(negedge clk);
        end
        chk("R1 unknown command ready", int'(in_ready), 1);
        run(8'h21, 5, 3, 1'b1, 0, "R1 dump after unknown frame");

        // R3: dump sweep, with stalls and wrap
        for (int a = 0; a < MSZ; a += 5) run(8'h21, a, (a % 9) + 1, 1'b1, a % 3, "R3 dump");
        run(8'h21, 60, 10, 1'b1, 1, "R3 dump wrap");
        run(8'h21, 16'h0FF0, 20, 1'b1, 0, "R3 dump high bits");
        run(8'h21, 7, MSZ + 6, 1'b1, 0, "R3 dump longer than memory");

        // R4: CRC sweeps over both memories
        for (int a = 0; a < MSZ; a += 7) run(8'h30, a, (a % 13) + 1, 1'b1, a % 2, "R4 crc program");
        for (int a = 3; a < MSZ; a += 9) run(8'h31, a, (a % 11) + 2, 1'b1, 2, "R4 crc data");
        run(8'h30, 50, 40, 1'b1, 0, "R4 crc program wrap");
        run(8'h31, 0, MSZ, 1'b1, 0, "R4 crc data full");

        // R5: zero length
        run(8'h21, 9, 0, 1'b1, 2, "R5 dump zero");
        run(8'h30, 9, 0, 1'b1, 0, "R5 crc program zero");
        run(8'h31, 9, 0, 1'b1, 3, "R5 crc data zero");

        // R6: locked frames
        run(8'h21, 4, 5, 1'b0, 2, "R6 locked dump");
        run(8'h30, 4, 5, 1'b0, 0, "R6 locked crc program");
        run(8'h31, 4, 5, 1'b0, 1, "R6 locked crc data");
        run(8'h31, 4, 5, 1'b1, 0, "R6 unlocked again");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule